// File: doc/BRIEF.md
# Segmented CAM search engine

This block is a small content-addressable memory. Its storage is a flat array of 32-bit segments. A run-time setting groups consecutive segments into table rows. Row `r` occupies segments `r*S` to `r*S+S-1`, where `S` (1 to 8) is the number of segments per row. The host loads the table through a 16-bit port, one half of a segment per write. The host marks rows as live or dead through a separate valid-bit port.

A search takes a key of up to 256 bits and a compare window given as a start bit and a length. It walks the row one segment per clock. On each step it narrows a per-row match vector. After the last segment it stores the lowest-numbered matching row, a hit flag and a several-rows-matched flag in result registers.

Several instances can be chained. Each instance passes downstream whether it or any earlier instance hit. Each instance also passes its own segments-per-row setting, so that a downstream instance can flag a mismatch.

Top module: `segcam`

## Requirements
- R1: The row count is NUM_SEG / S, rounded down, where S = `cfg_spe` + 1 is taken on a `cfg_we` write. A row whose index is at or beyond the row count never matches, even when its valid bit is set.
- R2: Row bit `b` is bit `b % 32` of segment `r*S + b/32`. Key bit `b` is `srch_key[b]`. Only bits with `srch_lo <= b < srch_lo + srch_len` and `b < 32*S` are compared. A length of zero makes every live row within the row count match.
- R3: A `srch_start` seen while idle raises `busy` at that edge. `busy` stays high for exactly S cycles. The results update at the edge where `busy` falls, and `done` is high for the following single cycle.
- R4: A host write with `host_hi` = 1 loads `host_wdata` into bits 31:16 of segment `host_addr`. With `host_hi` = 0 it loads bits 15:0. The other half is left unchanged. `host_rdata` shows, combinationally, the half of segment `host_addr` that `host_hi` selects.
- R5: Reset clears all valid bits, the stored data and the results. `vld_we` sets or clears the valid bit of row `vld_idx` to `vld_set`. A row whose valid bit is clear never matches.
- R6: `hit_idx` is the lowest matching row index, or 0 when no row matches. `multi` is 1 when two or more rows matched.
- R7: `hit` = local hit AND NOT `casc_hit_in`, and `casc_hit_out` = local hit OR `casc_hit_in`.
- R8: `casc_spe_out` shows S-1. `cfg_err` is 1 when `casc_head` is 0 and `casc_spe_in` differs from `casc_spe_out`.
- R9: A `cfg_we` or `srch_start` that arrives while `busy` is high is ignored.
- R10: The results and the local hit hold their values from one search completion to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Half-segment write strobe |
| host_addr | input | 6 | Segment address for write and read |
| host_hi | input | 1 | Half select: 1 selects bits 31:16, 0 selects bits 15:0 |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Selected half of the addressed segment |
| vld_we | input | 1 | Valid-bit write strobe |
| vld_idx | input | 6 | Row whose valid bit is written |
| vld_set | input | 1 | New valid value |
| cfg_we | input | 1 | Segments-per-row write strobe |
| cfg_spe | input | 3 | Segments per row minus one |
| srch_start | input | 1 | Start a search |
| srch_key | input | 256 | Search key |
| srch_lo | input | 8 | First bit of the compare window |
| srch_len | input | 9 | Width of the compare window in bits |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse after completion |
| hit | output | 1 | Local hit, masked by upstream hit |
| hit_idx | output | 6 | Lowest matching row |
| multi | output | 1 | Two or more rows matched |
| casc_head | input | 1 | 1 on the first instance of a chain |
| casc_hit_in | input | 1 | Some earlier instance hit |
| casc_spe_in | input | 3 | Upstream segments-per-row setting minus one |
| casc_hit_out | output | 1 | This or an earlier instance hit |
| casc_spe_out | output | 3 | Own segments-per-row setting minus one |
| cfg_err | output | 1 | Chain setting mismatch |

## Verification
The hardest situation to reach is a row that lies past the end of the table at a segment count that does not divide the storage evenly. With three segments per row, row 21 starts in the last segment. Its first segment compares correctly, and it can fail to match only through the later steps that fall off the array. The stimulus writes a key equal to that last segment, sets row 21 valid, and narrows the window to its first 32 bits. A second hard case is a configuration write and a restart that land in the middle of a multi-segment search, so the stimulus issues both one cycle after a start.

// File: rtl/segcam_pkg.sv
package segcam_pkg;

  localparam int SEG_W  = 32;
  localparam int HALF_W = 16;

  // Window mask for one segment step: bit j of the step covers row bit step*32+j.
  function automatic logic [SEG_W-1:0] win_mask(input int step, input int lo, input int len);
    logic [SEG_W-1:0] m;
    int b;
    m = '0;
    for (int j = 0; j < SEG_W; j++) begin
      b = step * SEG_W + j;
      m[j] = (b >= lo) && (b < lo + len);
    end
    return m;
  endfunction

  // True when two or more bits of a vector are set.
  function automatic logic several(input logic [63:0] v);
    return (v & (v - 64'd1)) != 64'd0;
  endfunction

endpackage

// File: rtl/segcam_store.sv
module segcam_store
  import segcam_pkg::*;
#(
  parameter int NUM_SEG = 64,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_we,
  input  logic [IDX_W-1:0]           host_addr,
  input  logic                       host_hi,
  input  logic [HALF_W-1:0]          host_wdata,
  output logic [HALF_W-1:0]          host_rdata,
  input  logic                       vld_we,
  input  logic [IDX_W-1:0]           vld_idx,
  input  logic                       vld_set,
  output logic [NUM_SEG*SEG_W-1:0]   seg_flat,
  output logic [NUM_SEG-1:0]         vld_q
);

  logic [SEG_W-1:0] mem [NUM_SEG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SEG; i++) mem[i] <= '0;
      vld_q <= '0;
    end else begin
      if (host_we) begin
        if (host_hi) mem[host_addr][SEG_W-1:HALF_W] <= host_wdata;
        else         mem[host_addr][HALF_W-1:0]     <= host_wdata;
      end
      if (vld_we) vld_q[vld_idx] <= vld_set;
    end
  end

  generate
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_flat
      assign seg_flat[g*SEG_W +: SEG_W] = mem[g];
    end
  endgenerate

  assign host_rdata = host_hi ? mem[host_addr][SEG_W-1:HALF_W] : mem[host_addr][HALF_W-1:0];

  // R5: out of reset, no row is live
  p_vld_cleared_r5: assert property (@(posedge clk) $past(!rst_n) && rst_n && !$past(vld_we) |-> vld_q == '0)
    else $error("valid bits not cleared by reset");

endmodule

// File: rtl/segcam_match.sv
module segcam_match
  import segcam_pkg::*;
#(
  parameter int NUM_SEG = 64,
  parameter int MAX_SPE = 8,
  localparam int IDX_W  = $clog2(NUM_SEG),
  localparam int SPE_W  = $clog2(MAX_SPE)
) (
  input  logic [NUM_SEG*SEG_W-1:0] seg_flat,
  input  logic [SPE_W:0]           spe,
  input  logic [SPE_W-1:0]         step,
  input  logic [IDX_W:0]           rows,
  input  logic [SEG_W-1:0]         key_seg,
  input  logic [SEG_W-1:0]         mask,
  output logic [NUM_SEG-1:0]       cmp
);

  generate
    for (genvar e = 0; e < NUM_SEG; e++) begin : g_row
      int addr;
      always_comb begin
        addr   = e * int'(spe) + int'(step);
        cmp[e] = 1'b0;
        if (e < int'(rows) && addr < NUM_SEG)
          cmp[e] = ((seg_flat[addr*SEG_W +: SEG_W] ^ key_seg) & mask) == '0;
      end
    end
  endgenerate

endmodule

// File: rtl/segcam_resolve.sv
module segcam_resolve
  import segcam_pkg::*;
#(
  parameter int NUM_SEG = 64,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic [NUM_SEG-1:0] mv,
  output logic               any,
  output logic               many,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    idx = '0;
    for (int i = NUM_SEG - 1; i >= 0; i--)
      if (mv[i]) idx = IDX_W'(i);
  end

  assign any  = |mv;
  assign many = several(64'(mv));

endmodule

// File: rtl/segcam.sv
module segcam
  import segcam_pkg::*;
#(
  parameter int NUM_SEG = 64,
  parameter int MAX_SPE = 8,
  parameter int LO_W    = 8,
  parameter int LEN_W   = 9,
  localparam int IDX_W  = $clog2(NUM_SEG),
  localparam int SPE_W  = $clog2(MAX_SPE),
  localparam int KEY_W  = MAX_SPE * SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_addr,
  input  logic              host_hi,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic              vld_we,
  input  logic [IDX_W-1:0]  vld_idx,
  input  logic              vld_set,
  input  logic              cfg_we,
  input  logic [SPE_W-1:0]  cfg_spe,
  input  logic              srch_start,
  input  logic [KEY_W-1:0]  srch_key,
  input  logic [LO_W-1:0]   srch_lo,
  input  logic [LEN_W-1:0]  srch_len,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic              multi,
  input  logic              casc_head,
  input  logic              casc_hit_in,
  input  logic [SPE_W-1:0]  casc_spe_in,
  output logic              casc_hit_out,
  output logic [SPE_W-1:0]  casc_spe_out,
  output logic              cfg_err
);

  logic [NUM_SEG*SEG_W-1:0] seg_flat;
  logic [NUM_SEG-1:0]       vld_q, cmp, mv_q, mv_base, mv_next;
  logic [SPE_W:0]           spe_q;
  logic [SPE_W-1:0]         step_q;
  logic [KEY_W-1:0]         key_q;
  logic [LO_W-1:0]          lo_q;
  logic [LEN_W-1:0]         len_q;
  logic                     busy_q, done_q, res_hit_q, res_multi_q;
  logic [IDX_W-1:0]         res_idx_q;

  // Named internal events
  logic             start_acc, cfg_acc, last_step, any_hit, many_hit;
  logic [IDX_W-1:0] low_idx;
  logic [IDX_W:0]   rows_cnt;
  logic [SEG_W-1:0] key_seg, seg_mask;

  assign start_acc = srch_start && !busy_q;
  assign cfg_acc   = cfg_we && !busy_q;
  assign last_step = busy_q && ({1'b0, step_q} == spe_q - 1'b1);
  assign rows_cnt  = (IDX_W+1)'(NUM_SEG / int'(spe_q));
  assign key_seg   = key_q[int'(step_q)*SEG_W +: SEG_W];
  assign seg_mask  = win_mask(int'(step_q), int'(lo_q), int'(len_q));
  assign mv_base   = (step_q == '0) ? vld_q : mv_q;
  assign mv_next   = mv_base & cmp;

  segcam_store #(.NUM_SEG(NUM_SEG)) u_store (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_hi(host_hi),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .vld_we(vld_we), .vld_idx(vld_idx), .vld_set(vld_set),
    .seg_flat(seg_flat), .vld_q(vld_q)
  );

  segcam_match #(.NUM_SEG(NUM_SEG), .MAX_SPE(MAX_SPE)) u_match (
    .seg_flat(seg_flat), .spe(spe_q), .step(step_q), .rows(rows_cnt),
    .key_seg(key_seg), .mask(seg_mask), .cmp(cmp)
  );

  segcam_resolve #(.NUM_SEG(NUM_SEG)) u_resolve (
    .mv(mv_next), .any(any_hit), .many(many_hit), .idx(low_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spe_q       <= (SPE_W+1)'(1);
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      step_q      <= '0;
      mv_q        <= '0;
      key_q       <= '0;
      lo_q        <= '0;
      len_q       <= '0;
      res_hit_q   <= 1'b0;
      res_multi_q <= 1'b0;
      res_idx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (cfg_acc) spe_q <= {1'b0, cfg_spe} + 1'b1;
      if (start_acc) begin
        busy_q <= 1'b1;
        step_q <= '0;
        key_q  <= srch_key;
        lo_q   <= srch_lo;
        len_q  <= srch_len;
      end else if (busy_q) begin
        mv_q   <= mv_next;
        step_q <= step_q + 1'b1;
        if (last_step) begin
          busy_q      <= 1'b0;
          done_q      <= 1'b1;
          res_hit_q   <= any_hit;
          res_multi_q <= many_hit;
          res_idx_q   <= low_idx;
        end
      end
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign hit_idx      = res_idx_q;
  assign multi        = res_multi_q;
  assign hit          = res_hit_q && !casc_hit_in;
  assign casc_hit_out = res_hit_q || casc_hit_in;
  assign casc_spe_out = SPE_W'(spe_q - 1'b1);
  assign cfg_err      = !casc_head && (casc_spe_in != casc_spe_out);

  // R3: the step counter never passes the row length
  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ({1'b0, step_q} < spe_q)) else $error("step past row end");

  // R3: the completion pulse follows the fall of busy
  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q))) else $error("done without busy");

  // R9: segments-per-row is frozen during a search
  p_spe_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(spe_q)) else $error("setting changed mid-search");

  // R1: the winning row lies inside the table
  p_idx_in_table_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (last_step && any_hit) |-> ({1'b0, low_idx} < rows_cnt)) else $error("row beyond table won");

  // R6: several matches imply a hit
  p_multi_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_multi_q |-> res_hit_q) else $error("multi without hit");

  // R7: an upstream hit suppresses the local flag
  p_casc_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    casc_hit_in |-> (!hit && casc_hit_out)) else $error("cascade priority broken");

  // R10: results hold while no search completes
  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !last_step |=> ($stable(res_idx_q) && $stable(res_hit_q) && $stable(res_multi_q)))
    else $error("results moved without completion");

endmodule

// File: tb/sim_segcam.sv
`timescale 1ns/1ps
module sim_segcam;

  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 0, host_hi = 0, vld_we = 0, vld_set = 0, cfg_we = 0, srch_start = 0;
  logic [5:0] host_addr = 0, vld_idx = 0;
  logic [15:0] host_wdata = 0;
  logic [2:0] cfg_spe = 0, casc_spe_in = 0;
  logic [255:0] srch_key = 0;
  logic [7:0] srch_lo = 0;
  logic [8:0] srch_len = 0;
  logic casc_head = 1, casc_hit_in = 0;
  logic [15:0] host_rdata;
  logic busy, done, hit, multi, casc_hit_out, cfg_err;
  logic [5:0] hit_idx;
  logic [2:0] casc_spe_out;

  segcam u0 (.*);

  always #2.5 clk = ~clk;

  // Reference model
  logic [31:0] m_mem [N];
  bit m_vld [N];
  int m_spe, m_cnt, m_idx, p_idx;
  bit m_busy, m_done, m_hit, m_multi, p_hit, p_multi;
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  function automatic void model_search(input logic [255:0] k, input int lo, input int len);
    int cnt;
    bit ok;
    cnt = 0; p_idx = 0;
    for (int e = N - 1; e >= 0; e--) begin
      if (e < N / m_spe && m_vld[e]) begin
        ok = 1;
        for (int b = 0; b < m_spe * 32; b++)
          if (b >= lo && b < lo + len && m_mem[e*m_spe + b/32][b%32] != k[b]) ok = 0;
        if (ok) begin cnt++; p_idx = e; end
      end
    end
    p_hit = cnt > 0;
    p_multi = cnt > 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_mem[i] = 0; m_vld[i] = 0; end
      m_spe = 1; m_busy = 0; m_done = 0; m_cnt = 0;
      m_hit = 0; m_multi = 0; m_idx = 0;
    end else begin
      if (host_we) begin
        if (host_hi) m_mem[host_addr][31:16] = host_wdata;
        else m_mem[host_addr][15:0] = host_wdata;
      end
      if (vld_we) m_vld[vld_idx] = vld_set;
      if (cfg_we && !m_busy) m_spe = int'(cfg_spe) + 1;
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          m_hit = p_hit; m_multi = p_multi; m_idx = p_idx;
        end
      end else if (srch_start) begin
        model_search(srch_key, int'(srch_lo), int'(srch_len));
        m_busy = 1; m_cnt = m_spe;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [31:0] seg;
      seg = m_mem[host_addr];
      chk("R3 busy", 64'(busy), 64'(m_busy));
      chk("R3 done", 64'(done), 64'(m_done));
      chk("R6 hit_idx", 64'(hit_idx), 64'(m_idx));
      chk("R6 multi", 64'(multi), 64'(m_multi));
      chk("R7 hit", 64'(hit), 64'(m_hit && !casc_hit_in));
      chk("R7 casc_hit_out", 64'(casc_hit_out), 64'(m_hit || casc_hit_in));
      chk("R8 casc_spe_out", 64'(casc_spe_out), 64'(m_spe - 1));
      chk("R8 cfg_err", 64'(cfg_err), 64'(!casc_head && (int'(casc_spe_in) != m_spe - 1)));
      chk("R4 host_rdata", 64'(host_rdata), 64'(host_hi ? seg[31:16] : seg[15:0]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] pat(input int i);
    return 32'(i) * 32'h9E3779B1 ^ 32'h5A5A1234;
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr_seg(input int a, input logic [31:0] d);
    host_we = 1; host_addr = 6'(a); host_hi = 1; host_wdata = d[31:16]; tick();
    host_hi = 0; host_wdata = d[15:0]; tick();
    host_we = 0;
  endtask

  task automatic set_vld(input int r, input bit v);
    vld_we = 1; vld_idx = 6'(r); vld_set = v; tick(); vld_we = 0;
  endtask

  task automatic set_cfg(input int s);
    cfg_we = 1; cfg_spe = 3'(s - 1); tick(); cfg_we = 0;
  endtask

  task automatic search(input logic [255:0] k, input int lo, input int len);
    srch_key = k; srch_lo = 8'(lo); srch_len = 9'(len);
    srch_start = 1; tick(); srch_start = 0;
    repeat (12) tick();
  endtask

  task automatic key_of_row(input int r, input int s, output logic [255:0] k);
    k = '0;
    for (int j = 0; j < s; j++) k[j*32 +: 32] = m_mem[r*s + j];
  endtask

  initial begin
    logic [255:0] k;
    repeat (3) tick();
    rst_n = 1; tick();
    // R5 R10: reset state
    chk("R5 valid cleared, no hit after reset", 64'(casc_hit_out), 64'd0);
    chk("R10 reset hit_idx", 64'(hit_idx), 64'd0);
    chk("R4 reset data", 64'(host_rdata), 64'd0);

    for (int i = 0; i < N; i++) wr_seg(i, pat(i));
    wr_seg(9, pat(5));
    for (int r = 0; r < 16; r++) set_vld(r, 1);

    // One segment per row, full window: rows 5 and 9 match
    k = '0; k[31:0] = pat(5);
    search(k, 0, 32);
    chk("R6 lowest of two", 64'(hit_idx), 64'd5);
    chk("R6 multi set", 64'(multi), 64'd1);

    // R5: invalid row drops out
    set_vld(5, 0);
    search(k, 0, 32);
    chk("R5 invalid row skipped", 64'(hit_idx), 64'd9);
    chk("R5 single match", 64'(multi), 64'd0);

    // R2: narrow window, upper key bits garbage
    k[31:8] = 24'hFFFFFF;
    search(k, 0, 8);
    chk("R2 window hit", 64'(hit), 64'd1);
    search(k, 4, 0);
    chk("R2 empty window", 64'(hit_idx), 64'd0);
    chk("R2 empty window multi", 64'(multi), 64'd1);

    // R4: half write leaves other half
    host_we = 1; host_addr = 6'd20; host_hi = 0; host_wdata = 16'hBEEF; tick(); host_we = 0;
    host_hi = 1; #1;
    chk("R4 upper half kept", 64'(host_rdata), 64'(pat(20) >> 16));

    // Three segments per row
    set_cfg(3);
    for (int r = 0; r < 22; r++) set_vld(r, 1);
    key_of_row(2, 3, k);
    search(k, 0, 96);
    chk("R2 three-segment row", 64'(hit_idx), 64'd2);

    // R9: configuration and restart mid-search are ignored
    srch_key = k; srch_lo = 0; srch_len = 9'd96; srch_start = 1; tick();
    cfg_we = 1; cfg_spe = 3'd0; tick(); cfg_we = 0; srch_start = 0;
    repeat (12) tick();
    chk("R9 setting unchanged", 64'(casc_spe_out), 64'd2);

    // R1: row 21 starts in the last segment and must not match
    k = '0; k[31:0] = m_mem[63];
    search(k, 0, 32);
    chk("R1 row beyond table", 64'(casc_hit_out), 64'd0);

    // Eight segments per row, window inside the row
    set_cfg(8);
    key_of_row(1, 8, k);
    k[99:0] = ~k[99:0];
    search(k, 100, 60);
    chk("R2 offset window", 64'(hit_idx), 64'd1);

    // R7 R8: cascade behaviour
    casc_hit_in = 1; tick();
    chk("R7 upstream masks hit", 64'(hit), 64'd0);
    casc_hit_in = 0; casc_head = 0; casc_spe_in = 3'd2; tick();
    chk("R8 mismatch flagged", 64'(cfg_err), 64'd1);
    casc_spe_in = 3'd7; tick();
    chk("R8 match clean", 64'(cfg_err), 64'd0);
    casc_head = 1;
    repeat (4) tick();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule